// File: doc/BRIEF.md
# Multichannel ADC Result Register Bank

This block is the register-side front end of a three-channel measurement converter. Results for the current, voltage and temperature channels arrive as 16-bit words, each with a one-cycle valid strobe. The bank latches each word into a read-only data register and raises a per-channel ready flag. A raised flag protects its register: any further result for that channel is dropped until software clears the flag. Software clears flags by reading the data registers. How much a read clears depends on which of the higher-priority channels are currently active, so that a read of a lower-priority channel does not discard a pending flag that belongs to a channel still running.

The bank also holds two 16-bit offset calibration coefficients, one for the current channel and one for the voltage channel. Each is loaded with a build-time default at reset. The hardware calibration engine overwrites a coefficient whenever it delivers a result. Software may overwrite a coefficient only when the converter is enabled and has stayed idle for a minimum time, 23 µs by default. This time is measured in clock cycles derived from a clock-frequency parameter. Writes that arrive too early are dropped.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, the three data registers and the status register read 0x0000, the current offset register reads OFS_CUR_INIT (0x8000 by default) and the voltage offset register reads OFS_VOLT_INIT (0x7F00 by default).
- R2: A result strobe on a channel whose ready flag is clear stores the word in that channel's data register and sets the flag on the following cycle. Status bit 0 is current, bit 1 is voltage and bit 2 is temperature.
- R3: While a channel's ready flag is set, a new result for that channel is discarded, and the data register keeps its old value.
- R4: A bus read of the current data register (offset 0x20) clears all three ready flags.
- R5: A bus read of the voltage data register (offset 0x24) clears flags 2 and 1 when cur_active is low. When cur_active is high it clears nothing.
- R6: A bus read of the temperature data register (offset 0x28) clears flag 2 only when both cur_active and volt_active are low. Otherwise it clears nothing.
- R7: The address map is: status at 0x2C (bits [2:0], upper bits zero, and reading it clears nothing), current offset at 0x30 and voltage offset at 0x34. Any other offset reads 0x0000, and bus_rdata is 0x0000 when bus_rd is low.
- R8: A software write to an offset register takes effect only when adc_enabled and adc_idle have both been high for at least IDLE_CYC consecutive rising edges before the write edge. IDLE_CYC is 2300 at 100 MHz and 23 µs. Any other software write to an offset register is ignored.
- R9: Dropping adc_enabled or adc_idle for even one cycle restarts the idle count from zero.
- R10: A calibration strobe overwrites its offset register with the calibration word whether or not the converter is idle. In a cycle with both a calibration strobe and a software write to the same register, the calibration word wins.
- R11: Bus writes to the data or status offsets are ignored.
- R12: When a result strobe arrives for a channel with a clear flag in the same cycle as a read that clears that flag, the result is stored and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle bus_rd is high |
| cur_valid | input | 1 | Current-channel result strobe |
| cur_data | input | 16 | Current-channel result |
| volt_valid | input | 1 | Voltage-channel result strobe |
| volt_data | input | 16 | Voltage-channel result |
| temp_valid | input | 1 | Temperature-channel result strobe |
| temp_data | input | 16 | Temperature-channel result |
| cur_active | input | 1 | Current channel is converting |
| volt_active | input | 1 | Voltage channel is converting |
| adc_enabled | input | 1 | Converter powered and enabled |
| adc_idle | input | 1 | Converter is in idle mode |
| cal_cur_valid | input | 1 | Current offset calibration result strobe |
| cal_cur_data | input | 16 | Current offset calibration result |
| cal_volt_valid | input | 1 | Voltage offset calibration result strobe |
| cal_volt_data | input | 16 | Voltage offset calibration result |

## Verification
The hardest states to reach are the edges of the idle qualification window. The stimulus raises adc_idle at a known falling edge and counts exactly IDLE_CYC-1 rising edges. It then places a write one edge before qualification, where the write must be dropped, and one edge at qualification, where it must land. A single-cycle drop of adc_idle after qualification, followed by an immediate write, shows that the count restarts. The same-cycle collisions, calibration against software write and result strobe against clearing read, are driven in one bus cycle and then read back.

// File: rtl/adcrb_pkg.sv
package adcrb_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;
    localparam int NUM_CH = 3;
    localparam int NUM_OFS = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_DAT_CUR  = 8'h20;
    localparam addr_t A_DAT_VOLT = 8'h24;
    localparam addr_t A_DAT_TEMP = 8'h28;
    localparam addr_t A_STATUS   = 8'h2C;
    localparam addr_t A_OFS_CUR  = 8'h30;
    localparam addr_t A_OFS_VOLT = 8'h34;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DAT_CUR,
        SEL_DAT_VOLT,
        SEL_DAT_TEMP,
        SEL_STATUS,
        SEL_OFS_CUR,
        SEL_OFS_VOLT
    } sel_e;

    typedef struct packed {
        logic  valid;
        word_t data;
    } strobe_t;

    function automatic sel_e decode(input addr_t a);
        case (a)
            A_DAT_CUR:  return SEL_DAT_CUR;
            A_DAT_VOLT: return SEL_DAT_VOLT;
            A_DAT_TEMP: return SEL_DAT_TEMP;
            A_STATUS:   return SEL_STATUS;
            A_OFS_CUR:  return SEL_OFS_CUR;
            A_OFS_VOLT: return SEL_OFS_VOLT;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic int unsigned idle_cycles(input longint unsigned hz,
                                                input longint unsigned ns);
        longint unsigned c;
        c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/adcrb_idle.sv
module adcrb_idle #(
    parameter int unsigned LIMIT = 2300
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic idle_i,
    output logic ok_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_W = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          run;

    assign run  = en_i && idle_i;
    assign ok_o = (cnt_q == LIM_W);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (cnt_q != LIM_W) cnt_q <= cnt_q + 1'b1;
    end

    // R9: leaving idle revokes qualification on the next cycle
    a_r9_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> !ok_o);
    // R8: once qualified, staying idle keeps qualification
    a_r8_hold_ok: assert property (@(posedge clk) disable iff (rst)
        (ok_o && run) |=> ok_o);
endmodule

// File: rtl/adcrb_chan.sv
module adcrb_chan
    import adcrb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t res_i,
    input  logic    clr_i,
    output word_t   data_o,
    output logic    rdy_o
);
    logic  take;
    word_t data_q;
    logic  rdy_q;

    assign take   = res_i.valid && !rdy_q;
    assign data_o = data_q;
    assign rdy_o  = rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            if (take) data_q <= res_i.data;
            rdy_q <= take || (rdy_q && !clr_i);
        end
    end

    // R2: an accepted result lands and raises the flag
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        (res_i.valid && !rdy_q) |=> (rdy_q && data_q == $past(res_i.data)));
    // R3: a pending flag freezes the data register
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        rdy_q |=> $stable(data_q));
    // R12: a result taken alongside a clear still leaves the flag set
    a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
        (res_i.valid && !rdy_q && clr_i) |=> rdy_q);
endmodule

// File: rtl/adcrb_ofs.sv
module adcrb_ofs
    import adcrb_pkg::*;
#(
    parameter word_t INIT = 16'h8000
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t cal_i,
    input  logic    sw_we_i,
    input  word_t   sw_data_i,
    input  logic    qual_i,
    output word_t   val_o
);
    word_t val_q;

    assign val_o = val_q;

    always_ff @(posedge clk) begin
        if (rst)                    val_q <= INIT;
        else if (cal_i.valid)       val_q <= cal_i.data;
        else if (sw_we_i && qual_i) val_q <= sw_data_i;
    end

    // R10: calibration result always lands, even against a software write
    a_r10_cal_wins: assert property (@(posedge clk) disable iff (rst)
        cal_i.valid |=> val_q == $past(cal_i.data));
    // R8: unqualified software writes leave the coefficient untouched
    a_r8_gate: assert property (@(posedge clk) disable iff (rst)
        (!cal_i.valid && !(sw_we_i && qual_i)) |=> $stable(val_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adcrb_pkg::*;
#(
    parameter longint unsigned CLK_HZ        = 100_000_000,
    parameter longint unsigned IDLE_NS       = 23_000,
    parameter logic [15:0]     OFS_CUR_INIT  = 16'h8000,
    parameter logic [15:0]     OFS_VOLT_INIT = 16'h7F00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        cur_valid,
    input  logic [15:0] cur_data,
    input  logic        volt_valid,
    input  logic [15:0] volt_data,
    input  logic        temp_valid,
    input  logic [15:0] temp_data,
    input  logic        cur_active,
    input  logic        volt_active,
    input  logic        adc_enabled,
    input  logic        adc_idle,
    input  logic        cal_cur_valid,
    input  logic [15:0] cal_cur_data,
    input  logic        cal_volt_valid,
    input  logic [15:0] cal_volt_data
);
    localparam int unsigned IDLE_CYC = idle_cycles(CLK_HZ, IDLE_NS);

    sel_e          sel;
    strobe_t       res   [NUM_CH];
    word_t         dat   [NUM_CH];
    logic [NUM_CH-1:0] rdy;
    logic [NUM_CH-1:0] clr;
    strobe_t       cal   [NUM_OFS];
    logic [NUM_OFS-1:0] sw_we;
    word_t         ofs   [NUM_OFS];
    logic          qual;
    logic          rd_cur, rd_volt, rd_temp;

    assign sel = decode(bus_addr);

    assign res[0] = '{valid: cur_valid,  data: cur_data};
    assign res[1] = '{valid: volt_valid, data: volt_data};
    assign res[2] = '{valid: temp_valid, data: temp_data};
    assign cal[0] = '{valid: cal_cur_valid,  data: cal_cur_data};
    assign cal[1] = '{valid: cal_volt_valid, data: cal_volt_data};

    assign rd_cur  = bus_rd && (sel == SEL_DAT_CUR);
    assign rd_volt = bus_rd && (sel == SEL_DAT_VOLT);
    assign rd_temp = bus_rd && (sel == SEL_DAT_TEMP);

    // clear spans shrink as higher-priority channels stay active
    always_comb begin
        clr[0] = rd_cur;
        clr[1] = rd_cur || (rd_volt && !cur_active);
        clr[2] = clr[1] || (rd_temp && !cur_active && !volt_active);
    end

    assign sw_we[0] = bus_wr && (sel == SEL_OFS_CUR);
    assign sw_we[1] = bus_wr && (sel == SEL_OFS_VOLT);

    adcrb_idle #(.LIMIT(IDLE_CYC)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .en_i   (adc_enabled),
        .idle_i (adc_idle),
        .ok_o   (qual)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        adcrb_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .res_i  (res[c]),
            .clr_i  (clr[c]),
            .data_o (dat[c]),
            .rdy_o  (rdy[c])
        );
    end

    for (genvar k = 0; k < NUM_OFS; k++) begin : g_ofs
        localparam word_t INIT = (k == 0) ? OFS_CUR_INIT : OFS_VOLT_INIT;
        adcrb_ofs #(.INIT(INIT)) u_ofs (
            .clk       (clk),
            .rst       (rst),
            .cal_i     (cal[k]),
            .sw_we_i   (sw_we[k]),
            .sw_data_i (bus_wdata),
            .qual_i    (qual),
            .val_o     (ofs[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_DAT_CUR:  bus_rdata = dat[0];
                SEL_DAT_VOLT: bus_rdata = dat[1];
                SEL_DAT_TEMP: bus_rdata = dat[2];
                SEL_STATUS:   bus_rdata = {{(WORD_W-NUM_CH){1'b0}}, rdy};
                SEL_OFS_CUR:  bus_rdata = ofs[0];
                SEL_OFS_VOLT: bus_rdata = ofs[1];
                default:      bus_rdata = '0;
            endcase
        end
    end

    logic any_res;
    assign any_res = cur_valid || volt_valid || temp_valid;

    // R4: current-data read with no incoming result empties the status
    a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
        (rd_cur && !any_res) |=> (rdy == '0));
    // R5: voltage-data read while current is active touches no flag
    a_r5_keep: assert property (@(posedge clk) disable iff (rst)
        (rd_volt && cur_active && !any_res) |=> $stable(rdy));
    // R6: temperature-data read with a higher channel active touches no flag
    a_r6_keep: assert property (@(posedge clk) disable iff (rst)
        (rd_temp && (cur_active || volt_active) && !any_res) |=> $stable(rdy));
    // R6: temperature read with both higher channels idle drops bit 2 only
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_temp && !cur_active && !volt_active && !any_res)
            |=> (!rdy[2] && rdy[1:0] == $past(rdy[1:0])));
    // R7: the read port is quiet between accesses
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/test_adc_result_bank.sv
`timescale 1ns/1ps
module test_adc_result_bank;

    localparam int LIMIT = 2300;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cur_valid = 0, volt_valid = 0, temp_valid = 0;
    logic [15:0] cur_data = '0, volt_data = '0, temp_data = '0;
    logic        cur_active = 0, volt_active = 0;
    logic        adc_enabled = 0, adc_idle = 0;
    logic        cal_cur_valid = 0, cal_volt_valid = 0;
    logic [15:0] cal_cur_data = '0, cal_volt_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_result_bank i_adc_result_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_valid(cur_valid), .cur_data(cur_data),
        .volt_valid(volt_valid), .volt_data(volt_data),
        .temp_valid(temp_valid), .temp_data(temp_data),
        .cur_active(cur_active), .volt_active(volt_active),
        .adc_enabled(adc_enabled), .adc_idle(adc_idle),
        .cal_cur_valid(cal_cur_valid), .cal_cur_data(cal_cur_data),
        .cal_volt_valid(cal_volt_valid), .cal_volt_data(cal_volt_data)
    );

    // vector: {op[1:0], req[3:0], addr[7:0], data[15:0]}
    // op 0: result on channel addr; op 1: read addr, expect data;
    // op 2: set activity {volt,cur} = data[1:0]
    localparam int NV = 28;
    localparam logic [29:0] VEC [NV] = '{
        {2'd2, 4'd5,  8'h00, 16'h0003},
        {2'd0, 4'd2,  8'h00, 16'h1234},
        {2'd0, 4'd2,  8'h01, 16'h5678},
        {2'd1, 4'd2,  8'h2C, 16'h0003},
        {2'd0, 4'd3,  8'h00, 16'h9999},
        {2'd1, 4'd3,  8'h20, 16'h1234},
        {2'd1, 4'd4,  8'h2C, 16'h0000},
        {2'd0, 4'd2,  8'h02, 16'h00AB},
        {2'd1, 4'd6,  8'h28, 16'h00AB},
        {2'd1, 4'd6,  8'h2C, 16'h0004},
        {2'd0, 4'd3,  8'h02, 16'h0BAD},
        {2'd1, 4'd3,  8'h28, 16'h00AB},
        {2'd1, 4'd5,  8'h24, 16'h5678},
        {2'd1, 4'd5,  8'h2C, 16'h0004},
        {2'd1, 4'd4,  8'h20, 16'h1234},
        {2'd1, 4'd4,  8'h2C, 16'h0000},
        {2'd2, 4'd5,  8'h00, 16'h0002},
        {2'd0, 4'd2,  8'h01, 16'h1111},
        {2'd0, 4'd2,  8'h02, 16'h3333},
        {2'd1, 4'd6,  8'h28, 16'h3333},
        {2'd1, 4'd6,  8'h2C, 16'h0006},
        {2'd1, 4'd5,  8'h24, 16'h1111},
        {2'd1, 4'd5,  8'h2C, 16'h0000},
        {2'd2, 4'd6,  8'h00, 16'h0000},
        {2'd0, 4'd2,  8'h02, 16'h4444},
        {2'd0, 4'd2,  8'h01, 16'h5555},
        {2'd1, 4'd6,  8'h28, 16'h4444},
        {2'd1, 4'd6,  8'h2C, 16'h0002}
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [15:0] exp,
                            input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic deliver(input int ch, input logic [15:0] d);
        @(negedge clk);
        case (ch)
            0: begin cur_valid = 1'b1; cur_data = d; end
            1: begin volt_valid = 1'b1; volt_data = d; end
            default: begin temp_valid = 1'b1; temp_data = d; end
        endcase
        @(negedge clk);
        cur_valid = 1'b0; volt_valid = 1'b0; temp_valid = 1'b0;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_check(8'h20, 16'h0000, "R1 cur data");
        rd_check(8'h24, 16'h0000, "R1 volt data");
        rd_check(8'h28, 16'h0000, "R1 temp data");
        rd_check(8'h2C, 16'h0000, "R1 status");
        rd_check(8'h30, 16'h8000, "R1 cur offset");
        rd_check(8'h34, 16'h7F00, "R1 volt offset");
        // R7: unmapped offset and idle read port
        rd_check(8'h3C, 16'h0000, "R7 unmapped");
        #1 check("R7 no read", bus_rdata, 16'h0000);

        // R11: writes to read-only locations ignored
        wr(8'h20, 16'hFFFF);
        wr(8'h2C, 16'h0007);
        rd_check(8'h20, 16'h0000, "R11 data write");
        rd_check(8'h2C, 16'h0000, "R11 status write");

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  ad;
            logic [15:0] dt;
            {op, rq, ad, dt} = VEC[i];
            case (op)
                2'd0: deliver(int'(ad), dt);
                2'd1: rd_check(ad, dt, $sformatf("R%0d vec %0d", rq, i));
                default: begin
                    @(negedge clk);
                    cur_active = dt[0]; volt_active = dt[1];
                end
            endcase
        end
        rd_check(8'h24, 16'h5555, "R5 final volt read");
        rd_check(8'h2C, 16'h0000, "R5 clears bits 2 and 1");

        // R12: result and clearing read in the same cycle
        @(negedge clk);
        bus_addr = 8'h20; bus_rd = 1'b1;
        volt_valid = 1'b1; volt_data = 16'hAAAA;
        @(negedge clk);
        bus_rd = 1'b0; volt_valid = 1'b0;
        rd_check(8'h2C, 16'h0002, "R12 flag kept");
        rd_check(8'h24, 16'hAAAA, "R12 data kept");

        // R8: converter enabled but busy, write dropped
        adc_enabled = 1'b1;
        wr(8'h30, 16'h1111);
        rd_check(8'h30, 16'h8000, "R8 busy write");
        // R8: exact qualification edge
        @(negedge clk);
        adc_idle = 1'b1;
        repeat (LIMIT - 1) @(posedge clk);
        wr(8'h30, 16'h2222);
        rd_check(8'h30, 16'h8000, "R8 one edge early");
        wr(8'h30, 16'h1234);
        rd_check(8'h30, 16'h1234, "R8 qualified write");
        wr(8'h34, 16'h4321);
        rd_check(8'h34, 16'h4321, "R8 volt qualified write");

        // R9: one-cycle idle drop restarts the count
        @(negedge clk);
        adc_idle = 1'b0;
        @(negedge clk);
        adc_idle = 1'b1;
        wr(8'h30, 16'h3333);
        rd_check(8'h30, 16'h1234, "R9 restart");
        // R8: disabled converter blocks writes
        repeat (LIMIT + 2) @(posedge clk);
        @(negedge clk);
        adc_enabled = 1'b0;
        wr(8'h30, 16'h5555);
        rd_check(8'h30, 16'h1234, "R8 disabled");

        // R10: calibration lands while not idle-qualified
        @(negedge clk);
        cal_cur_valid = 1'b1; cal_cur_data = 16'hCAFE;
        @(negedge clk);
        cal_cur_valid = 1'b0;
        rd_check(8'h30, 16'hCAFE, "R10 cal not idle");
        // R10: calibration beats a qualified software write
        adc_enabled = 1'b1;
        repeat (LIMIT + 2) @(posedge clk);
        @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 16'h0001; bus_wr = 1'b1;
        cal_volt_valid = 1'b1; cal_volt_data = 16'hBEEF;
        @(negedge clk);
        bus_wr = 1'b0; cal_volt_valid = 1'b0;
        rd_check(8'h34, 16'hBEEF, "R10 cal priority");

        done = 1;
        summary();
    end
endmodule